// File: doc/BRIEF.md
# Three-Level Transmit Test Pattern Generator

This block produces the transmit-side compliance patterns of a 100 Mb/s single-pair Ethernet PHY that signals with three levels. A three-bit mode code chooses between normal operation and five test patterns. On every cycle where the symbol-clock enable is high, the block emits one ternary symbol (-1, 0 or +1) as a two-bit code. The code is registered, so it stays constant between enables.

The patterns are these. A droop square wave made of N symbols at +1 followed by N symbols at -1. An alternating -1/+1 tone at half the symbol rate, with one code for the master role and one for the slave role. A three-level pseudo-random sequence that repeats every 2047 symbols. A free-running three-level random sequence that does not repeat at that length. Each pattern keeps running for as long as its code stays selected. A change of code restarts the new pattern at its first symbol on the next enable. An illegal selection forces the output to 0 and raises an error flag.

Top module: `tri_level_pattern_gen`

## Requirements
- R1: While reset is high, and after its release until the first enable, tx_sym is 00 and tx_err is 0.
- R2: tx_sym and tx_err change only on the clock edge at which sym_en is high. The symbol code is 00 for 0, 01 for +1 and 11 for -1. The code 10 never appears.
- R3: Mode code 0 (normal) gives symbol 0 with tx_err low.
- R4: Mode code 1 gives HALF_LEN symbols at +1, then HALF_LEN symbols at -1, repeating. HALF_LEN defaults to 34.
- R5: Mode code 2 gives -1, +1, -1, +1, and so on, starting at -1, in either role.
- R6: Mode code 3 gives the same alternating sequence as R5 when role_is_master is 0. When role_is_master is 1, the output is 0 and tx_err is 1.
- R7: Mode code 4 uses an 11-bit register s, loaded with 11'h7FF when the pattern starts. The symbol is taken from the bit pair (s[10], s[9]): 00 gives 0, 01 gives +1, 10 gives -1, 11 gives 0. After each symbol, s advances two steps. One step is s = {s[9:0], s[10]^s[8]}. The symbol stream repeats every 2047 symbols and at no shorter period that divides 2047.
- R8: Mode code 5 uses a 33-bit register loaded with 33'h1FFFFFFFF. It uses the same bit-pair mapping on bits (s[32], s[31]) and the same two steps per symbol, with one step being {s[31:0], s[32]^s[19]}. Its stream does not repeat after 2047 symbols.
- R9: A change of mode code or role has no effect until the next enable. At that enable, the newly selected pattern starts at its first symbol. A pattern also restarts when its code becomes legal again after an error.
- R10: Mode codes 6 and 7 give symbol 0 with tx_err set to 1.
- R11: While the code stays unchanged, the selected pattern continues without end and with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Symbol-clock enable; one symbol per high cycle |
| mode_sel | input | 3 | Pattern select code |
| role_is_master | input | 1 | 1 when the PHY role is master, 0 when it is slave |
| tx_sym | output | 2 | Ternary symbol: 00 = 0, 01 = +1, 11 = -1 |
| tx_err | output | 1 | Illegal selection flag |

## Verification
The hardest property to reach from the ports is the exact 2047-symbol period of the mode 4 stream. It shows only over thousands of consecutive enables. To reach it, the bench records two full periods and compares the first against the second. It also confirms that shifts of 23 and 89 symbols, the divisors of 2047, do not line up the stream. The same comparison on mode 5 shows that it does not repeat. The recovery path after an error is reached by holding mode 3 while flipping role_is_master between enables.

// File: rtl/tlpg_pkg.sv
package tlpg_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b11
    } tsym_t;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_NORMAL = 3'd0;
    localparam logic [MODE_W-1:0] MODE_DROOP  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_JIT_M  = 3'd2;
    localparam logic [MODE_W-1:0] MODE_JIT_S  = 3'd3;
    localparam logic [MODE_W-1:0] MODE_DIST   = 3'd4;
    localparam logic [MODE_W-1:0] MODE_PSD    = 3'd5;

    // two successive generator bits -> one ternary symbol
    function automatic tsym_t bits_to_sym(input logic b1, input logic b0);
        case ({b1, b0})
            2'b01:   return SYM_POS;
            2'b10:   return SYM_NEG;
            default: return SYM_ZERO;
        endcase
    endfunction

    function automatic logic mode_bad(input logic [MODE_W-1:0] m, input logic master);
        return (m > MODE_PSD) || ((m == MODE_JIT_S) && master);
    endfunction

endpackage

// File: rtl/tlpg_square.sv
module tlpg_square
    import tlpg_pkg::*;
#(
    parameter int HALF_LEN = 34
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  restart,
    output tsym_t sym_o
);
    localparam int PERIOD = 2 * HALF_LEN;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_cur;

    assign cnt_cur = restart ? '0 : cnt_q;
    assign sym_o   = (cnt_cur < CW'(HALF_LEN)) ? SYM_POS : SYM_NEG;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_cur == CW'(PERIOD - 1)) ? '0 : cnt_cur + 1'b1;
        end
    end
endmodule

// File: rtl/tlpg_alternate.sv
module tlpg_alternate
    import tlpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  restart,
    output tsym_t sym_o
);
    logic ph_q;
    logic ph_cur;

    assign ph_cur = restart ? 1'b0 : ph_q;
    assign sym_o  = ph_cur ? SYM_POS : SYM_NEG;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= 1'b0;
        end else if (en) begin
            ph_q <= ~ph_cur;
        end
    end
endmodule

// File: rtl/tlpg_lfsr.sv
module tlpg_lfsr
    import tlpg_pkg::*;
#(
    parameter int           W    = 11,
    parameter int           TAP  = 9,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  restart,
    output tsym_t sym_o
);
    logic [W-1:0] st_q;
    logic [W-1:0] cur;

    function automatic logic [W-1:0] step(input logic [W-1:0] v);
        return {v[W-2:0], v[W-1] ^ v[TAP-1]};
    endfunction

    assign cur   = restart ? SEED : st_q;
    assign sym_o = bits_to_sym(cur[W-1], cur[W-2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEED;
        end else if (en) begin
            st_q <= step(step(cur));
        end
    end
endmodule

// File: rtl/tri_level_pattern_gen.sv
module tri_level_pattern_gen
    import tlpg_pkg::*;
#(
    parameter int HALF_LEN = 34
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  logic [2:0] mode_sel,
    input  logic       role_is_master,
    output logic [1:0] tx_sym,
    output logic       tx_err
);
    logic [MODE_W-1:0] cur_mode_q;
    logic              cur_ok_q;
    logic              bad;
    logic              restart;
    tsym_t             sym_q;
    tsym_t             nxt;
    tsym_t             sq_sym, alt_sym, dist_sym, psd_sym;
    logic              en_sq, en_alt, en_dist, en_psd;

    assign bad     = mode_bad(mode_sel, role_is_master);
    assign restart = (mode_sel != cur_mode_q) || !cur_ok_q;
    assign en_sq   = sym_en && !bad && (mode_sel == MODE_DROOP);
    assign en_alt  = sym_en && !bad && ((mode_sel == MODE_JIT_M) || (mode_sel == MODE_JIT_S));
    assign en_dist = sym_en && !bad && (mode_sel == MODE_DIST);
    assign en_psd  = sym_en && !bad && (mode_sel == MODE_PSD);

    tlpg_square #(.HALF_LEN(HALF_LEN)) u_square (
        .clk(clk), .rst(rst), .en(en_sq), .restart(restart), .sym_o(sq_sym)
    );

    tlpg_alternate u_alt (
        .clk(clk), .rst(rst), .en(en_alt), .restart(restart), .sym_o(alt_sym)
    );

    tlpg_lfsr #(.W(11), .TAP(9), .SEED(11'h7FF)) u_dist (
        .clk(clk), .rst(rst), .en(en_dist), .restart(restart), .sym_o(dist_sym)
    );

    tlpg_lfsr #(.W(33), .TAP(20), .SEED(33'h1FFFFFFFF)) u_psd (
        .clk(clk), .rst(rst), .en(en_psd), .restart(restart), .sym_o(psd_sym)
    );

    always_comb begin
        case (mode_sel)
            MODE_DROOP:             nxt = sq_sym;
            MODE_JIT_M, MODE_JIT_S: nxt = alt_sym;
            MODE_DIST:              nxt = dist_sym;
            MODE_PSD:               nxt = psd_sym;
            default:                nxt = SYM_ZERO;
        endcase
        if (bad) nxt = SYM_ZERO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q      <= SYM_ZERO;
            tx_err     <= 1'b0;
            cur_mode_q <= MODE_NORMAL;
            cur_ok_q   <= 1'b0;
        end else if (sym_en) begin
            sym_q      <= nxt;
            tx_err     <= bad;
            cur_mode_q <= mode_sel;
            cur_ok_q   <= !bad;
        end
    end

    assign tx_sym = sym_q;
endmodule

// File: rtl/tlpg_chk.sv
module tlpg_chk (
    input logic       clk,
    input logic       rst,
    input logic       sym_en,
    input logic [2:0] mode_sel,
    input logic       role_is_master,
    input logic [1:0] tx_sym,
    input logic       tx_err
);
    logic       rst_d_q;
    logic       seen_q;
    logic [2:0] last_mode_q;

    always_ff @(posedge clk) begin
        if (rst_d_q === 1'b1) begin
            a_r1_reset_state: assert (tx_sym == 2'b00 && !tx_err)
                else $error("R1 output not idle after reset");
        end
        rst_d_q <= rst;
        if (rst) begin
            seen_q      <= 1'b0;
            last_mode_q <= 3'd0;
        end else if (sym_en) begin
            seen_q      <= 1'b1;
            last_mode_q <= mode_sel;
        end
    end

    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        tx_sym != 2'b10);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> ($stable(tx_sym) && $stable(tx_err)));

    a_r3_normal_zero: assert property (@(posedge clk) disable iff (rst)
        (sym_en && mode_sel == 3'd0) |=> (tx_sym == 2'b00 && !tx_err));

    a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
        (sym_en && mode_sel == 3'd2 && seen_q && last_mode_q == 3'd2)
        |=> (tx_sym != $past(tx_sym) && tx_sym != 2'b00));

    a_r6_master_illegal: assert property (@(posedge clk) disable iff (rst)
        (sym_en && mode_sel == 3'd3 && role_is_master) |=> (tx_err && tx_sym == 2'b00));

    a_r9_restart_square: assert property (@(posedge clk) disable iff (rst)
        (sym_en && mode_sel == 3'd1 && (!seen_q || last_mode_q != 3'd1)) |=> (tx_sym == 2'b01));

    a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
        (sym_en && mode_sel > 3'd5) |=> (tx_err && tx_sym == 2'b00));
endmodule

bind tri_level_pattern_gen tlpg_chk i_tlpg_chk (
    .clk(clk), .rst(rst), .sym_en(sym_en), .mode_sel(mode_sel),
    .role_is_master(role_is_master), .tx_sym(tx_sym), .tx_err(tx_err)
);

// File: tb/test_tri_level_pattern_gen.sv
module test_tri_level_pattern_gen;
    localparam int N = 34;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_en = 1'b0;
    logic       role_is_master = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic [1:0] tx_sym;
    logic       tx_err;

    int tests = 0;
    int fails = 0;
    logic [1:0] last_sym = 2'b00;
    logic       last_err = 1'b0;
    logic [1:0] rec [0:4093];

    always #2 clk = ~clk;

    tri_level_pattern_gen #(.HALF_LEN(N)) i_tri_level_pattern_gen (
        .clk(clk), .rst(rst), .sym_en(sym_en), .mode_sel(mode_sel),
        .role_is_master(role_is_master), .tx_sym(tx_sym), .tx_err(tx_err)
    );

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] map2(input logic b1, input logic b0);
        if (b1 == 1'b0 && b0 == 1'b1) return 2'b01;
        if (b1 == 1'b1 && b0 == 1'b0) return 2'b11;
        return 2'b00;
    endfunction

    task automatic run_mode(input logic [2:0] m, input logic master, input int n,
                            input int gap, input bit record, input string tag);
        int          cnt = 0;
        bit          ph = 0;
        logic [10:0] s4 = 11'h7FF;
        logic [32:0] s5 = 33'h1FFFFFFFF;
        logic [1:0]  exp;
        logic        eerr;
        @(negedge clk);
        mode_sel = m;
        role_is_master = master;
        sym_en = 1'b0;
        repeat (2) @(negedge clk);
        // R9: new selection not visible before an enable
        chk({tag, " R9 pending sym"}, tx_sym, last_sym);
        chk({tag, " R9 pending err"}, {1'b0, tx_err}, {1'b0, last_err});
        eerr = (m > 3'd5) || (m == 3'd3 && master);
        for (int k = 0; k < n; k++) begin
            sym_en = 1'b1;
            @(posedge clk);
            #1;
            sym_en = 1'b0;
            if (eerr) exp = 2'b00;
            else begin
                case (m)
                    3'd1: begin
                        exp = (cnt < N) ? 2'b01 : 2'b11;
                        cnt = (cnt + 1) % (2 * N);
                    end
                    3'd2, 3'd3: begin
                        exp = ph ? 2'b01 : 2'b11;
                        ph = !ph;
                    end
                    3'd4: begin
                        exp = map2(s4[10], s4[9]);
                        for (int j = 0; j < 2; j++) s4 = {s4[9:0], s4[10] ^ s4[8]};
                    end
                    3'd5: begin
                        exp = map2(s5[32], s5[31]);
                        for (int j = 0; j < 2; j++) s5 = {s5[31:0], s5[32] ^ s5[19]};
                    end
                    default: exp = 2'b00;
                endcase
            end
            chk(tag, tx_sym, exp);
            chk({tag, " err"}, {1'b0, tx_err}, {1'b0, eerr});
            if (record) rec[k] = tx_sym;
            last_sym = exp;
            last_err = eerr;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                #1;
                chk({tag, " R2 hold"}, tx_sym, exp);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 during reset", tx_sym, 2'b00);
        chk("R1 err during reset", {1'b0, tx_err}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 after release", tx_sym, 2'b00);
        chk("R1 err after release", {1'b0, tx_err}, 2'b00);

        run_mode(3'd0, 1'b0, 5,   0, 0, "R3 normal");
        run_mode(3'd1, 1'b0, 209, 0, 0, "R4 R11 square");
        run_mode(3'd2, 1'b1, 11,  0, 0, "R5 alt master");
        run_mode(3'd1, 1'b1, 100, 2, 0, "R4 R9 square gapped");
        run_mode(3'd3, 1'b0, 9,   1, 0, "R6 alt slave");
        run_mode(3'd3, 1'b1, 4,   0, 0, "R6 slave code as master");
        run_mode(3'd3, 1'b0, 6,   0, 0, "R9 recover after error");
        run_mode(3'd6, 1'b0, 3,   0, 0, "R10 code 6");
        run_mode(3'd7, 1'b1, 3,   0, 0, "R10 code 7");
        run_mode(3'd4, 1'b0, 4094, 0, 1, "R7 prbs");
        begin
            int mism = 0, m23 = 0, m89 = 0;
            for (int i = 0; i < 2047; i++) begin
                if (rec[i] !== rec[i + 2047]) mism++;
                if (rec[i] !== rec[i + 23]) m23++;
                if (rec[i] !== rec[i + 89]) m89++;
            end
            chk("R7 period 2047 mismatches", 2'(mism != 0), 2'd0);
            chk("R7 not periodic at 23", 2'(m23 != 0), 2'd1);
            chk("R7 not periodic at 89", 2'(m89 != 0), 2'd1);
        end
        run_mode(3'd5, 1'b1, 4094, 0, 1, "R8 random");
        begin
            int mism = 0;
            for (int i = 0; i < 2047; i++)
                if (rec[i] !== rec[i + 2047]) mism++;
            chk("R8 no repeat at 2047", 2'(mism != 0), 2'd1);
        end
        run_mode(3'd2, 1'b0, 6,  0, 0, "R5 alt slave role");
        run_mode(3'd4, 1'b0, 20, 1, 0, "R9 R7 prbs restart");
        run_mode(3'd0, 1'b0, 4,  0, 0, "R3 back to normal");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule